// File: doc/BRIEF.md
# Two-Level Address Translator with Set-Associative Buffer

The block turns a 15-bit virtual address into a physical address. The virtual address splits into a 7-bit byte offset within a 128-byte page and an 8-bit virtual page number (VPN). The two low VPN bits select one of four sets in a small translation buffer, and the upper six bits form the tag. Each set has four ways. A tag match in the selected set is a hit, and it returns the stored physical page number (PPN).

On a buffer miss the block searches a small page table held in registers, comparing against the full VPN. A write port fills the table. Each slot holds a VPN, a PPN and a valid bit. If the first matching slot is valid, the translation is returned and copied into the selected set, replacing the way chosen by a per-set round-robin pointer. If no slot matches, or the first matching slot is invalid, the block reports a page fault and returns no translation. All results appear one cycle after the request, together with a one-cycle done pulse.

Top module: `vtlb_xlate`

## Requirements
- R1: The reported page number `vpn_o` equals bits 14..7 of the requested address.
- R2: `idx_o` is bits 1..0 of the page number and `tag_o` is bits 7..2. For example, address 0x0712 gives page 0x0E, set 2 and tag 0x03.
- R3: If a valid way in the selected set holds the request tag, the result is hit=1, miss=0 and fault=0, and the PPN comes from that way.
- R4: If no valid way in the selected set holds the tag, the result is miss=1 and hit=0. Every done pulse carries exactly one of hit and miss.
- R5: On a miss, the table slots are compared against the full page number and the lowest-numbered matching slot decides the result. If no slot matches, fault=1 and `ppn_o` and `pa_o` are 0.
- R6: If the deciding slot has its valid bit at 0, the result is fault=1 with `ppn_o` and `pa_o` at 0, even when a higher slot holds a valid match.
- R7: If the deciding slot is valid, the result is miss=1 and fault=0, with that slot's PPN. The translation is written into the selected set, so a later request to the same page hits.
- R8: When a translation exists, `pa_o` is the PPN concatenated with the unchanged low 7 address bits.
- R9: Each set has its own victim pointer. The pointer starts at way 0 after reset and advances by one, wrapping, on every refill of that set. Filling a set with a fifth distinct page evicts the first page, and the other sets are left untouched.
- R10: Results are registered and appear in the cycle after `req`, with `done` high for exactly that cycle. Requests may arrive on back-to-back cycles, and `done` stays low when there is no request.
- R11: After reset the buffer is empty, every table slot is invalid, and `done`, `hit`, `miss`, `fault` and `pa_o` are 0.
- R12: A table write with `pt_we` high replaces the slot chosen by `pt_idx`. The new contents are seen by requests in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Translation request strobe |
| va | input | 15 | Virtual address to translate |
| pt_we | input | 1 | Page-table slot write enable |
| pt_idx | input | 3 | Slot number to write |
| pt_vpn | input | 8 | Page number stored in the slot |
| pt_ppn | input | 6 | Physical page number stored in the slot |
| pt_vld | input | 1 | Valid bit stored in the slot |
| done | output | 1 | One-cycle result strobe |
| vpn_o | output | 8 | Virtual page number of the request |
| idx_o | output | 2 | Selected set |
| tag_o | output | 6 | Compared tag |
| hit | output | 1 | Translation found in the buffer |
| miss | output | 1 | Translation not in the buffer |
| fault | output | 1 | No valid translation exists |
| ppn_o | output | 6 | Physical page number, 0 on fault |
| pa_o | output | 13 | Physical address, 0 on fault |

## Verification
A corrupted buffer way, tag or round-robin pointer does not show at once. It appears at the next request to that same set, as a hit where a miss was due or the reverse, or as the wrong PPN. Victim errors can stay hidden until a fifth distinct page enters the set and an older page is requested again. A bad refill shows within two requests: the request that should refill, and the repeat request that should then hit. The bench replays the buffer contents and pointers from the requirements, so each of these shows up as a mismatch on the very result that exposes it.

// File: rtl/vtlb_xlate.sv
module vtlb_xlate #(
  parameter int VA_W  = 15,
  parameter int OFF_W = 7,
  parameter int SET_W = 2,
  parameter int WAYS  = 4,
  parameter int PPN_W = 6,
  parameter int PT_N  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic [VA_W-1:0]        va,
  input  logic                   pt_we,
  input  logic [$clog2(PT_N)-1:0] pt_idx,
  input  logic [VA_W-OFF_W-1:0]  pt_vpn,
  input  logic [PPN_W-1:0]       pt_ppn,
  input  logic                   pt_vld,
  output logic                   done,
  output logic [VA_W-OFF_W-1:0]  vpn_o,
  output logic [SET_W-1:0]       idx_o,
  output logic [VA_W-OFF_W-SET_W-1:0] tag_o,
  output logic                   hit,
  output logic                   miss,
  output logic                   fault,
  output logic [PPN_W-1:0]       ppn_o,
  output logic [PPN_W+OFF_W-1:0] pa_o
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic             tv   [SETS][WAYS];
  logic [TAG_W-1:0] ttag [SETS][WAYS];
  logic [PPN_W-1:0] tppn [SETS][WAYS];
  logic [WAY_W-1:0] rr   [SETS];

  logic             pv   [PT_N];
  logic [VPN_W-1:0] pvpn [PT_N];
  logic [PPN_W-1:0] pppn [PT_N];

  wire [VPN_W-1:0] vpn = va[VA_W-1:OFF_W];
  wire [SET_W-1:0] set = vpn[SET_W-1:0];
  wire [TAG_W-1:0] tag = vpn[VPN_W-1:SET_W];

  logic             t_hit, p_found, p_ok;
  logic [PPN_W-1:0] t_ppn, p_ppn;

  always_comb begin
    t_hit = 1'b0;
    t_ppn = '0;
    for (int w = 0; w < WAYS; w++)
      if (!t_hit && tv[set][w] && ttag[set][w] == tag) begin
        t_hit = 1'b1;
        t_ppn = tppn[set][w];
      end
    p_found = 1'b0;
    p_ok    = 1'b0;
    p_ppn   = '0;
    for (int i = 0; i < PT_N; i++)
      if (!p_found && pvpn[i] == vpn) begin
        p_found = 1'b1;
        p_ok    = pv[i];
        p_ppn   = pppn[i];
      end
  end

  wire             refill  = req && !t_hit && p_ok;
  wire             res_ok  = t_hit || p_ok;
  wire [PPN_W-1:0] res_ppn = t_hit ? t_ppn : (p_ok ? p_ppn : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        rr[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tv[s][w]   <= 1'b0;
          ttag[s][w] <= '0;
          tppn[s][w] <= '0;
        end
      end
      for (int i = 0; i < PT_N; i++) begin
        pv[i]   <= 1'b0;
        pvpn[i] <= '0;
        pppn[i] <= '0;
      end
    end else begin
      if (refill) begin
        tv[set][rr[set]]   <= 1'b1;
        ttag[set][rr[set]] <= tag;
        tppn[set][rr[set]] <= p_ppn;
        rr[set] <= (rr[set] == WAY_W'(WAYS - 1)) ? '0 : rr[set] + 1'b1;
      end
      if (pt_we) begin
        pv[pt_idx]   <= pt_vld;
        pvpn[pt_idx] <= pt_vpn;
        pppn[pt_idx] <= pt_ppn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      vpn_o <= '0;
      idx_o <= '0;
      tag_o <= '0;
      hit   <= 1'b0;
      miss  <= 1'b0;
      fault <= 1'b0;
      ppn_o <= '0;
      pa_o  <= '0;
    end else begin
      done <= req;
      if (req) begin
        vpn_o <= vpn;
        idx_o <= set;
        tag_o <= tag;
        hit   <= t_hit;
        miss  <= !t_hit;
        fault <= !res_ok;
        ppn_o <= res_ppn;
        pa_o  <= res_ok ? {res_ppn, va[OFF_W-1:0]} : '0;
      end
    end
  end

  AST_VPN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vpn_o == $past(va[VA_W-1:OFF_W])); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({hit, miss}) == 1); // R4
  AST_FAULT_NO_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (miss && ppn_o == '0 && pa_o == '0)); // R5
  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> pa_o == {ppn_o, $past(va[OFF_W-1:0])}); // R8
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done); // R10
endmodule

// File: tb/vtlb_xlate_tb.sv
`timescale 1ns/1ps
module vtlb_xlate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [14:0] va = '0;
  logic pt_we = 1'b0;
  logic [2:0] pt_idx = '0;
  logic [7:0] pt_vpn = '0;
  logic [5:0] pt_ppn = '0;
  logic pt_vld = 1'b0;
  logic done, hit, miss, fault;
  logic [7:0] vpn_o;
  logic [1:0] idx_o;
  logic [5:0] tag_o, ppn_o;
  logic [12:0] pa_o;

  always #2.5 clk = ~clk;

  vtlb_xlate u_dut (.clk(clk), .rst_n(rst_n), .req(req), .va(va), .pt_we(pt_we),
    .pt_idx(pt_idx), .pt_vpn(pt_vpn), .pt_ppn(pt_ppn), .pt_vld(pt_vld), .done(done),
    .vpn_o(vpn_o), .idx_o(idx_o), .tag_o(tag_o), .hit(hit), .miss(miss), .fault(fault),
    .ppn_o(ppn_o), .pa_o(pa_o));

  typedef struct {
    logic [41:0] v;
    string       rq;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0;
  bit finished = 0;

  logic       m_v   [4][4];
  logic [5:0] m_tag [4][4];
  logic [5:0] m_ppn [4][4];
  logic [1:0] m_rr  [4];
  logic       m_pv  [8];
  logic [7:0] m_pvpn[8];
  logic [5:0] m_pppn[8];

  function automatic logic [41:0] pack_out(logic [7:0] a, logic [1:0] b, logic [5:0] c,
      logic h, logic m, logic f, logic [5:0] p, logic [12:0] x);
    return {a, b, c, h, m, f, p, x};
  endfunction

  task automatic check(bit ok, string rq, logic [41:0] act, logic [41:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [14:0] a, input string rq);
    logic [7:0] vp;
    logic [1:0] s;
    logic [5:0] t, p;
    logic h, found, ok;
    exp_t e;
    vp = a[14:7]; s = vp[1:0]; t = vp[7:2];
    h = 0; p = 0; found = 0; ok = 0;
    for (int w = 0; w < 4; w++)
      if (!h && m_v[s][w] && m_tag[s][w] == t) begin h = 1; p = m_ppn[s][w]; end
    if (!h) begin
      for (int i = 0; i < 8; i++)
        if (!found && m_pvpn[i] == vp) begin found = 1; ok = m_pv[i]; p = m_pppn[i]; end
      if (ok) begin
        m_v[s][m_rr[s]] = 1; m_tag[s][m_rr[s]] = t; m_ppn[s][m_rr[s]] = p;
        m_rr[s] = m_rr[s] + 2'd1;
      end else p = 0;
    end
    e.v = pack_out(vp, s, t, h, !h, !(h || ok), p, (h || ok) ? {p, a[6:0]} : 13'd0);
    e.rq = rq;
    q.push_back(e);
    req = 1'b1; va = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pt_write(input int slot, input logic [7:0] vp, input logic [5:0] pp,
      input logic vl);
    pt_we = 1'b1; pt_idx = 3'(slot); pt_vpn = vp; pt_ppn = pp; pt_vld = vl;
    m_pv[slot] = vl; m_pvpn[slot] = vp; m_pppn[slot] = pp;
    @(negedge clk);
    pt_we = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      logic [41:0] act;
      exp_t e;
      act = pack_out(vpn_o, idx_o, tag_o, hit, miss, fault, ppn_o, pa_o);
      if (q.size() == 0) check(0, "R10 unexpected done", act, '0);
      else begin
        e = q.pop_front();
        check(act == e.v, e.rq, act, e.v);
      end
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) begin m_v[s][w] = 0; m_tag[s][w] = 0; m_ppn[s][w] = 0; end
    end
    for (int i = 0; i < 8; i++) begin m_pv[i] = 0; m_pvpn[i] = 0; m_pppn[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({done, hit, miss, fault, pa_o} == '0, "R11 reset state",
          42'({done, hit, miss, fault, pa_o}), '0);

    issue(15'h0712, "R1 R2 R5 example address faults");
    @(negedge clk);
    pt_write(0, 8'h0E, 6'h15, 1'b1);
    issue(15'h0712, "R7 R8 R12 table refill");
    issue(15'h0701, "R3 R8 repeat page hits");
    pt_write(1, 8'h21, 6'h07, 1'b0);
    pt_write(2, 8'h21, 6'h09, 1'b1);
    issue(15'h10AA, "R6 first match invalid faults");
    issue(15'h0000, "R5 R6 reset slots invalid");
    for (int k = 0; k < 5; k++) pt_write(3 + k, {6'(k + 1), 2'b01}, 6'(k + 40), 1'b1);
    for (int k = 0; k < 5; k++) issue({6'(k + 1), 2'b01, 7'(k * 9)}, "R4 R9 fill set");
    issue({6'd3, 2'b01, 7'h33}, "R9 surviving way hits");
    issue({6'd1, 2'b01, 7'h7F}, "R9 first page evicted");
    issue({6'd2, 2'b01, 7'h00}, "R9 second victim evicted");
    issue({6'd5, 2'b01, 7'h11}, "R9 R3 newest page hits");
    issue(15'h0755, "R9 other set untouched");
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R10 idle no done", 42'(done), '0);
    pt_write(6, 8'h0E, 6'h3F, 1'b1);
    issue(15'h0766, "R12 cached entry still hits");
    pt_write(1, 8'h21, 6'h2A, 1'b1);
    issue(15'h10FF, "R12 rewritten slot used");
    issue(15'h1080, "R3 refilled page hits");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R10 every request answered", 42'(q.size()), '0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule